// File: doc/BRIEF.md
# Serial successive-approximation converter sequencer

This block is the digital half of an 8-bit successive-approximation converter with a four-wire serial port. The conversion steps are paced by the serial clock. The host lowers chip select and clocks a control byte in. The control byte begins with a start bit. The byte selects the clock mode and the output coding. Once the byte is complete, the block raises a strobe. It then makes one bit decision per serial-clock period, using an external comparator that compares the analog input with the trial code the block presents. The decided bits are shifted out on the data output, most significant first.

All serial inputs are sampled by the system clock `clk`. Serial-clock edges are found by comparing successive samples, so every output moves two `clk` cycles after the serial edge that causes it. The data and strobe outputs each have an output-enable companion for an external tri-state pad. A timer measures how long the conversion takes and flags any conversion that runs past a parameterised number of `clk` cycles. Selecting the unsupported internal-clock mode is flagged, and the rest of the transaction is ignored.

Top module: `sar_serial_seq`

## Requirements
- R1: While waiting for a transaction, rising serial-clock edges with `din` = 0 are ignored. The first rising edge with `din` = 1 is taken as bit 7 (the start bit) of an 8-bit control byte. The remaining bits are taken MSB first on the next seven rising edges. Bit 2 selects the coding (1 = unipolar, 0 = bipolar) and bit 0 selects the clock mode (1 = external clock).
- R2: `sstrb` rises after the rising edge that carries control bit 0 and falls after the second rising edge that follows it, so it stays high for exactly two serial-clock periods. Otherwise it is low while chip select is low.
- R3: On each of the eight rising edges after the control byte, the current trial bit of `trial_code` is kept unless `comp_lo` = 1, in which case it is cleared. The next lower bit is then set as the new trial. `trial_code` starts at 0x80, and after the eighth decision it holds the converted code.
- R4: On the eight falling edges that follow those decisions, `dout` shows the result bits, bit 7 first. Every later falling edge drives `dout` to 0.
- R5: In unipolar coding the shifted-out result equals the SAR code. In bipolar coding bit 7 of the result is inverted.
- R6: While `cs_n` is high, `dout_oe` and `sstrb_oe` are low, and any transfer in progress is abandoned; the next transfer must begin again with a start bit. After `cs_n` falls, both enables rise with `sstrb` = 0.
- R7: `timeout` rises if the time from the end of the control byte to the eighth decision is more than `TIMEOUT_CYCLES` clk cycles. It stays high until `cs_n` goes high.
- R8: If control bit 0 is 0, `unsup_mode` goes high. For the rest of that transaction `sstrb` and `dout` stay 0. The flag clears when `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; shifts data and paces the decisions |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control input |
| comp_lo | input | 1 | Comparator output: 1 when the analog input is below the trial code |
| trial_code | output | 8 | SAR register presented to the converter DAC |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the `dout` pad |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Output enable for the `sstrb` pad |
| timeout | output | 1 | The conversion took longer than the limit |
| unsup_mode | output | 1 | Internal-clock mode was requested |

## Verification
The hardest state to reach from the ports is an over-long conversion. The decisions advance only on serial-clock edges, so the limit can be exceeded only by stretching the serial clock while chip select stays low. The bench builds the block with a small limit. It runs one conversion with a fast serial clock, where the flag must stay low, and one with a five-times-slower clock, where it must rise. The bench's comparator model compares a chosen input value against the live `trial_code` output. This lets the result byte, the strobe window and the trailing zeros be checked against that value for both codings.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    localparam int RES_W   = 8;
    localparam int CMD_W   = 8;
    localparam int UNI_POS = 2;
    localparam int CNT_MAX = (RES_W > CMD_W) ? RES_W : CMD_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int IDX_W   = $clog2(RES_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CONV,
        ST_TAIL,
        ST_UNSUP
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             uni;
        logic             sstrb;
        logic             dout;
        logic             unsup;
        logic             oe;
    } seq_reg_t;

    typedef struct packed {
        logic sclk;
        logic sclk_prev;
        logic cs_n;
        logic din;
        logic comp;
    } smp_reg_t;
endpackage

// File: rtl/sadc_edge.sv
module sadc_edge
    import sadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    input  logic comp_lo,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_hi,
    output logic din_s,
    output logic comp_s
);
    smp_reg_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.sclk      = sclk;
        s_d.sclk_prev = s_q.sclk;
        s_d.cs_n      = cs_n;
        s_d.din       = din;
        s_d.comp      = comp_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sclk: 1'b0, sclk_prev: 1'b0, cs_n: 1'b1, din: 1'b0, comp: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_rise = s_q.sclk & ~s_q.sclk_prev;
    assign sclk_fall = ~s_q.sclk & s_q.sclk_prev;
    assign cs_hi     = s_q.cs_n;
    assign din_s     = s_q.din;
    assign comp_s    = s_q.comp;
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic         comp_lo,
    output logic [W-1:0] code
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  code_d, code_q;
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        code_d = code_q;
        idx_d  = idx_q;
        if (start) begin
            code_d        = '0;
            code_d[W-1]   = 1'b1;
            idx_d         = IW'(W - 1);
        end else if (step) begin
            if (comp_lo) begin
                code_d[idx_q] = 1'b0;
            end
            if (idx_q != '0) begin
                code_d[idx_q - 1'b1] = 1'b1;
                idx_d                = idx_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            idx_q  <= '0;
        end else begin
            code_q <= code_d;
            idx_q  <= idx_d;
        end
    end

    assign code = code_q;

    AST_SAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !step) |=> $stable(code_q)); // R3
    AST_SAR_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ($countones(code_q) == 1 && code_q[W-1])); // R3
endmodule

// File: rtl/sadc_timer.sv
module sadc_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && cnt_q <= LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = cnt_q > LIM;

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired); // R7
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sadc_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic             comp_lo,
    output logic [RES_W-1:0] trial_code,
    output logic             dout,
    output logic             dout_oe,
    output logic             sstrb,
    output logic             sstrb_oe,
    output logic             timeout,
    output logic             unsup_mode
);
    localparam logic [CNT_W-1:0] UNI_ARR  = CNT_W'(CMD_W - 1 - UNI_POS);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] RES_END  = CNT_W'(RES_W);

    logic sclk_rise, sclk_fall, cs_hi, din_s, comp_s;
    logic sar_start, sar_step, tmr_run;
    logic [RES_W-1:0] code;
    logic [IDX_W-1:0] bit_sel;
    seq_reg_t r_d, r_q;

    sadc_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .din       (din),
        .comp_lo   (comp_lo),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_hi     (cs_hi),
        .din_s     (din_s),
        .comp_s    (comp_s)
    );

    sadc_sar #(.W(RES_W)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sar_start),
        .step    (sar_step),
        .comp_lo (comp_s),
        .code    (code)
    );

    assign tmr_run = (r_q.st == ST_CONV) && (r_q.cnt != RES_END);

    sadc_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .clear   (cs_hi | sar_start),
        .expired (timeout)
    );

    assign bit_sel = IDX_W'(RES_END - r_q.cnt);

    always_comb begin
        r_d       = r_q;
        sar_start = 1'b0;
        sar_step  = 1'b0;
        r_d.oe    = ~cs_hi;
        if (cs_hi) begin
            r_d.st    = ST_IDLE;
            r_d.cnt   = '0;
            r_d.sstrb = 1'b0;
            r_d.dout  = 1'b0;
            r_d.unsup = 1'b0;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (sclk_rise && din_s) begin
                        r_d.st  = ST_CMD;
                        r_d.cnt = CNT_W'(1);
                    end
                end
                ST_CMD: begin
                    if (sclk_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == UNI_ARR) begin
                            r_d.uni = din_s;
                        end
                        if (r_q.cnt == CMD_LAST) begin
                            r_d.cnt = '0;
                            if (din_s) begin
                                r_d.st    = ST_CONV;
                                r_d.sstrb = 1'b1;
                                sar_start = 1'b1;
                            end else begin
                                r_d.st    = ST_UNSUP;
                                r_d.unsup = 1'b1;
                            end
                        end
                    end
                end
                ST_CONV: begin
                    if (sclk_rise && r_q.cnt != RES_END) begin
                        sar_step = 1'b1;
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(1)) begin
                            r_d.sstrb = 1'b0;
                        end
                    end else if (sclk_fall && r_q.cnt != '0) begin
                        r_d.dout = code[bit_sel] ^ (~r_q.uni & (r_q.cnt == CNT_W'(1)));
                        if (r_q.cnt == RES_END) begin
                            r_d.st = ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (sclk_fall) begin
                        r_d.dout = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, uni: 1'b0, sstrb: 1'b0,
                     dout: 1'b0, unsup: 1'b0, oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign trial_code = code;
    assign dout       = r_q.dout;
    assign dout_oe    = r_q.oe;
    assign sstrb      = r_q.sstrb;
    assign sstrb_oe   = r_q.oe;
    assign unsup_mode = r_q.unsup;

    AST_STRB_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sstrb |-> (r_q.st == ST_CONV)); // R2
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TAIL && sclk_fall && !cs_hi) |=> !r_q.dout); // R4
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (r_q.st == ST_IDLE && !r_q.oe)); // R6
    AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_UNSUP) |-> (!r_q.sstrb && !r_q.dout && r_q.unsup)); // R8
endmodule

// File: tb/sar_serial_seq_test.sv
module sar_serial_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic comp_lo;
    logic [7:0] vin = 8'h00;
    logic [7:0] trial_code;
    logic dout, dout_oe, sstrb, sstrb_oe, timeout, unsup_mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [7:0] CTRL_UNI = 8'b1000_0101;
    localparam logic [7:0] CTRL_BIP = 8'b1000_0001;
    localparam logic [7:0] CTRL_INT = 8'b1000_0100;

    always #5 clk = ~clk;

    assign comp_lo = (vin < trial_code);

    sar_serial_seq #(.TIMEOUT_CYCLES(400)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .din        (din),
        .comp_lo    (comp_lo),
        .trial_code (trial_code),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .sstrb      (sstrb),
        .sstrb_oe   (sstrb_oe),
        .timeout    (timeout),
        .unsup_mode (unsup_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic d, input int h, output logic pre_dout, output logic hi_strb);
        din = d;
        repeat (h) @(negedge clk);
        pre_dout = dout;
        sclk = 1'b1;
        repeat (h) @(negedge clk);
        hi_strb = sstrb;
        sclk = 1'b0;
    endtask

    task automatic select_on(input string tag);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        chk({tag, " R6 enables on"}, {6'b0, dout_oe, sstrb_oe}, 8'h03);
        chk({tag, " R6 strobe low"}, {7'b0, sstrb}, 8'h00);
    endtask

    task automatic select_off(input string tag);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({tag, " R6 enables off"}, {6'b0, dout_oe, sstrb_oe}, 8'h00);
        chk({tag, " R7 R8 flags cleared"}, {6'b0, timeout, unsup_mode}, 8'h00);
    endtask

    task automatic run_conv(input string tag, input logic [7:0] ctrl, input int nz,
                            input logic [7:0] v, input int h, input logic exp_to);
        logic pre [1:12];
        logic hs [1:11];
        logic p, s, s0, tail_bad;
        logic [7:0] got, exp_b;
        vin = v;
        exp_b = ctrl[2] ? v : (v ^ 8'h80);
        select_on(tag);
        for (int i = 0; i < nz; i++) pulse(1'b0, h, p, s);
        for (int i = 7; i >= 0; i--) begin
            pulse(ctrl[i], h, p, s);
            if (i == 0) s0 = s;
        end
        for (int j = 1; j <= 11; j++) pulse(1'b0, h, pre[j], hs[j]);
        repeat (h) @(negedge clk);
        pre[12] = dout;
        for (int j = 2; j <= 9; j++) got[9 - j] = pre[j];
        tail_bad = pre[10] | pre[11] | pre[12];
        chk({tag, " R2 strobe window"}, {5'b0, s0, hs[1], hs[2]}, 8'h06);
        chk({tag, " R1 R4 R5 result byte"}, got, exp_b);
        chk({tag, " R4 trailing zeros"}, {7'b0, tail_bad}, 8'h00);
        chk({tag, " R3 final SAR code"}, trial_code, v);
        chk({tag, " R7 timeout flag"}, {7'b0, timeout}, {7'b0, exp_to});
        chk({tag, " R8 no unsupported flag"}, {7'b0, unsup_mode}, 8'h00);
        select_off(tag);
    endtask

    task automatic t_reset;
        chk("reset R6 enables", {6'b0, dout_oe, sstrb_oe}, 8'h00);
        chk("reset R7 R8 flags", {6'b0, timeout, unsup_mode}, 8'h00);
        chk("reset R4 dout", {7'b0, dout}, 8'h00);
    endtask

    task automatic t_unipolar;
        run_conv("uni A5", CTRL_UNI, 3, 8'hA5, 8, 1'b0);
        run_conv("uni FF", CTRL_UNI, 0, 8'hFF, 8, 1'b0);
        run_conv("uni 00", CTRL_UNI, 1, 8'h00, 8, 1'b0);
    endtask

    task automatic t_bipolar;
        run_conv("bip 3C", CTRL_BIP, 2, 8'h3C, 8, 1'b0);
        run_conv("bip 80", CTRL_BIP, 0, 8'h80, 8, 1'b0);
    endtask

    task automatic t_abort;
        logic p, s;
        select_on("abort");
        pulse(1'b1, 8, p, s);
        pulse(1'b0, 8, p, s);
        pulse(1'b1, 8, p, s);
        select_off("abort");
        run_conv("after abort R6", CTRL_UNI, 2, 8'h5A, 8, 1'b0);
    endtask

    task automatic t_unsupported;
        logic p, s, any_strb, any_dout;
        any_strb = 1'b0;
        any_dout = 1'b0;
        vin = 8'h37;
        select_on("unsup");
        for (int i = 7; i >= 0; i--) pulse(CTRL_INT[i], 8, p, s);
        for (int j = 1; j <= 11; j++) begin
            pulse(1'b1, 8, p, s);
            any_strb |= s;
            any_dout |= p;
        end
        chk("unsup R8 flag", {7'b0, unsup_mode}, 8'h01);
        chk("unsup R8 strobe quiet", {7'b0, any_strb}, 8'h00);
        chk("unsup R8 dout quiet", {7'b0, any_dout}, 8'h00);
        select_off("unsup");
    endtask

    task automatic t_timeout;
        run_conv("slow R7", CTRL_UNI, 0, 8'h69, 40, 1'b1);
        run_conv("fast again R7", CTRL_BIP, 0, 8'hC3, 8, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_unipolar();
        t_bipolar();
        t_abort();
        t_unsupported();
        t_timeout();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule